// File: doc/BRIEF.md
# Parallel Prefix Scan Unit

This block takes a vector of N unsigned integer elements and returns every running prefix of that vector under one associative operator. Output element 1 repeats input element 1, and each later output element folds together all input elements from position 1 up to its own position. The operator is fixed when the block is built: integer addition or bitwise OR. The carries and running totals come from a tree of operator nodes that is log2(N) levels deep, where a serial accumulator would need N-1 steps in a chain.

Vectors enter and leave on valid/ready streams. A transfer happens on a rising clock edge where valid and ready are both high. The producer holds `in_data` steady while `in_valid` is high and `in_ready` is low. The consumer may lower `out_ready` at any time. A stalled result then stays on `out_data` until the consumer accepts it.

With `REG_OUT` set, a single output register sits after the tree. It accepts a new vector whenever it is empty or its current result is being accepted in the same cycle. With `REG_OUT` cleared, the block is purely combinational from input to output and the handshake passes straight through. Element i of a packed bus sits at bits [i*width +: width], counting from i = 0 for element 1.

Top module: `prefix_scan`

## Requirements
- R1: Output element 1 equals input element 1, zero-extended. Output element i equals the operator folded over input elements 1 through i.
- R2: With the addition operator, every output element is W+log2(N) bits wide and holds its true sum without truncation. For all-ones inputs with W=8 and N=8, element i equals 255*i, and the top element equals 2040.
- R3: With the OR operator (`OP` = 1), output element i is the bitwise OR of input elements 1 through i, zero-extended to the output width.
- R4: With addition, the input 1,2,3,4,5,6,0,0 (element 1 first) yields 1,3,6,10,15,21,21,21. The top element is therefore the fold of the whole vector.
- R5: While reset is asserted and right after it, a registered block shows `out_valid` low and `in_ready` high.
- R6: With `REG_OUT` = 1, a vector accepted on one edge appears on `out_data` with `out_valid` high after that edge.
- R7: With `REG_OUT` = 1, while `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is low. A waiting input is therefore not taken. The stalled result leaves on the first edge where `out_ready` is high, and a waiting input is accepted on that same edge.
- R8: With `REG_OUT` = 0, `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle, and the result is available without a clock edge.
- R9: Whenever `out_valid` is high, the prefixes are ordered. With addition, each element is greater than or equal to the one below it. With OR, each element has every bit of the one below it set.
- R10: With `REG_OUT` = 1, the register drops `out_valid` after its result is accepted if no new vector arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block can take the input vector |
| in_data | input | N*W | Packed input elements, element 1 in the low bits |
| out_valid | output | 1 | Result vector present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | N*(W+log2 N) | Packed prefix results, element 1 in the low bits |

## Verification
On every clock edge, the assertions check that the results are ordered (non-decreasing sums, OR results that only gain bits). They also check that a stalled result holds its value, that an empty register always shows ready, and that an accepted vector is valid on the next edge. Only the bench's scenarios can show that each prefix has the right value. The bench does this by comparing the results against a serial reference loop for table vectors, for all-zero and all-ones inputs, and for the worked example. It also covers the exact cycles of a stall followed by a release, and the combinational pass-through variant with the OR operator.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic {SCAN_ADD = 1'b0, SCAN_OR = 1'b1} scan_op_e;
endpackage

// File: rtl/scan_node.sv
module scan_node #(
  parameter int OW = 11,
  parameter scan_pkg::scan_op_e OP = scan_pkg::SCAN_ADD
) (
  input  logic [OW-1:0] hi_i,
  input  logic [OW-1:0] lo_i,
  output logic [OW-1:0] y_o
);
  generate
    if (OP == scan_pkg::SCAN_ADD) begin : g_add
      assign y_o = hi_i + lo_i;
    end else begin : g_or
      assign y_o = hi_i | lo_i;
    end
  endgenerate
endmodule

// File: rtl/scan_tree.sv
module scan_tree #(
  parameter int N  = 8,
  parameter int OW = 11,
  parameter scan_pkg::scan_op_e OP = scan_pkg::SCAN_ADD
) (
  input  logic [N*OW-1:0] leaf_i,
  output logic [N*OW-1:0] pre_o
);
  localparam int LG = $clog2(N);

  logic [OW-1:0] lvl [LG+1][N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_leaf
      assign lvl[0][i] = leaf_i[i*OW +: OW];
      assign pre_o[i*OW +: OW] = lvl[LG][i];
    end
    for (genvar k = 0; k < LG; k++) begin : g_lvl
      localparam int D = 1 << k;
      for (genvar i = 0; i < N; i++) begin : g_col
        if (i >= D) begin : g_op
          scan_node #(.OW(OW), .OP(OP)) u_node (
            .hi_i (lvl[k][i]),
            .lo_i (lvl[k][i-D]),
            .y_o  (lvl[k+1][i])
          );
        end else begin : g_pass
          assign lvl[k+1][i] = lvl[k][i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/scan_outreg.sv
module scan_outreg #(
  parameter int DW  = 88,
  parameter bit REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);
  generate
    if (REG) begin : g_reg
      logic          v_q;
      logic [DW-1:0] d_q;

      assign s_ready = !v_q || m_ready;
      assign m_valid = v_q;
      assign m_data  = d_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (s_ready) begin
          v_q <= s_valid;
          if (s_valid) d_q <= s_data;
        end
      end

      // R6
      accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> m_valid);
      // R7
      stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
      // R5
      empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !m_valid |-> s_ready);
      // R10
      drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && !s_valid) |=> !m_valid);
    end else begin : g_comb
      assign s_ready = m_ready;
      assign m_valid = s_valid;
      assign m_data  = s_data;
    end
  endgenerate
endmodule

// File: rtl/prefix_scan.sv
module prefix_scan #(
  parameter int N   = 8,
  parameter int W   = 8,
  parameter scan_pkg::scan_op_e OP = scan_pkg::SCAN_ADD,
  parameter bit REG_OUT = 1'b1,
  localparam int LG = $clog2(N),
  localparam int OW = W + LG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [N*W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [N*OW-1:0] out_data
);
  logic [N*OW-1:0] leaf;
  logic [N*OW-1:0] pre;

  generate
    for (genvar i = 0; i < N; i++) begin : g_ext
      assign leaf[i*OW +: OW] = {{LG{1'b0}}, in_data[i*W +: W]};
    end
  endgenerate

  scan_tree #(.N(N), .OW(OW), .OP(OP)) u_tree (
    .leaf_i (leaf),
    .pre_o  (pre)
  );

  scan_outreg #(.DW(N*OW), .REG(REG_OUT)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (pre),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (out_data)
  );

  generate
    for (genvar i = 1; i < N; i++) begin : g_order
      if (OP == scan_pkg::SCAN_ADD) begin : g_add
        // R9
        sum_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
          out_valid |-> (out_data[i*OW +: OW] >= out_data[(i-1)*OW +: OW]));
      end else begin : g_or
        // R9
        or_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
          out_valid |-> ((out_data[(i-1)*OW +: OW] & ~out_data[i*OW +: OW]) == '0));
      end
    end
  endgenerate
endmodule

// File: tb/prefix_scan_test.sv
module prefix_scan_test;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int OW = W + 3;
  localparam int NV = 6;
  localparam logic [N*W-1:0] VEC [NV] = '{
    64'h0000_0605_0403_0201,
    64'h0000_0000_0000_0000,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'hAA55_AA55_AA55_AA55,
    64'h8000_0000_0000_0000,
    64'h3C91_07E2_5D10_F04B
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic oready_or = 1'b1;
  logic [N*W-1:0] in_data = '0;
  logic in_ready, out_valid, in_ready_or, out_valid_or;
  logic [N*OW-1:0] out_data, out_data_or;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prefix_scan #(.N(N), .W(W), .OP(scan_pkg::SCAN_ADD), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  prefix_scan #(.N(N), .W(W), .OP(scan_pkg::SCAN_OR), .REG_OUT(1'b0)) uut_or (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_or),
    .in_data(in_data), .out_valid(out_valid_or), .out_ready(oready_or),
    .out_data(out_data_or));

  function automatic logic [N*OW-1:0] ref_scan(input logic [N*W-1:0] v, input bit use_or);
    logic [OW-1:0] acc = '0;
    logic [N*OW-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (use_or) acc = acc | OW'(v[i*W +: W]);
      else        acc = acc + OW'(v[i*W +: W]);
      r[i*OW +: OW] = acc;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [N*OW-1:0] act, input logic [N*OW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R5 reset valid", {87'b0, out_valid}, '0);
    check("R5 reset ready", {87'b0, in_ready}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 after reset", {86'b0, out_valid, in_ready}, 1);

    for (int t = 0; t < NV; t++) begin
      in_data = VEC[t];
      in_valid = 1'b1;
      #1;
      check("R3/R8 or comb", out_data_or, ref_scan(VEC[t], 1'b1));
      check("R8 valid pass", {87'b0, out_valid_or}, 1);
      @(negedge clk);
      in_valid = 1'b0;
      check("R6 valid", {87'b0, out_valid}, 1);
      check("R1/R2 sum", out_data, ref_scan(VEC[t], 1'b0));
      if (t == 0) begin
        check("R4 elem6", 88'(out_data[5*OW +: OW]), 21);
        check("R4 top", 88'(out_data[7*OW +: OW]), 21);
        check("R4 elem3", 88'(out_data[2*OW +: OW]), 6);
      end
      if (t == 2) check("R2 top all-ones", 88'(out_data[7*OW +: OW]), 2040);
    end
    @(negedge clk);
    check("R10 drains", {87'b0, out_valid}, 0);

    // back-pressure
    out_ready = 1'b0;
    in_data = VEC[5];
    in_valid = 1'b1;
    @(negedge clk);
    check("R7 stalled out", out_data, ref_scan(VEC[5], 1'b0));
    check("R7 ready low", {87'b0, in_ready}, 0);
    in_data = VEC[0];
    @(negedge clk);
    check("R7 holds", out_data, ref_scan(VEC[5], 1'b0));
    check("R7 still valid", {87'b0, out_valid}, 1);
    out_ready = 1'b1;
    #1;
    check("R7 ready on release", {87'b0, in_ready}, 1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 next taken", out_data, ref_scan(VEC[0], 1'b0));

    oready_or = 1'b0;
    #1;
    check("R8 ready pass", {87'b0, in_ready_or}, 0);
    check("R8 idle valid", {87'b0, out_valid_or}, 0);
    oready_or = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule